// File: doc/BRIEF.md
# Five-Port Mesh Router with Per-Output Input Queues

This block is one node of a 4x4 two-dimensional mesh on-chip network. It has five ports: a local port towards the attached core, plus north, south, east and west links to neighbouring nodes. Every input port holds four small flit queues, one bound to each output it can reach. A flit is written straight into the queue for its output, so the node does no route computation and no virtual-channel allocation of its own. A flit whose output is busy also cannot hold back flits behind it that are bound elsewhere.

Each flit carries its final destination in its top four bits. The node at the far end of a link needs to know which of its queues the flit belongs in, and it cannot work this out itself. So the sending node computes dimension-order routing one hop ahead and sends a queue-select code with the flit. Arbitration and crossbar traversal happen in the same cycle. A flit at the head of its queue that wins its output is registered onto that output at the next clock edge.

Flow control is by credits. For every queue of every downstream receiver, the node keeps a credit counter. When a queue of its own is dequeued, it returns a one-cycle credit pulse upstream in that same cycle.

Top module: `vroute_top`

## Requirements
- R1: Reset has the following effects. All output valids go low. All credit-return bits go low. All queues become empty. Every downstream credit counter is set to 4, the queue depth. Every arbiter pointer is set to port 0.
- R2: Ports are encoded local=0, north=1, south=2, east=3, west=4. A valid flit on input port p with queue-select q is written into the queue bound to output q when q<p, and to output q+1 otherwise.
- R3: A flit that is alone at the head of its queue, with credit available, is granted in the cycle after the edge that wrote it. It appears on its output port at the following edge with its 16 data bits unchanged. Its transfer takes two edges from input to output.
- R4: Credit-return bit p*4+q is high in exactly the cycle in which queue q of input p is granted. No other credit-return bit is high in that cycle.
- R5: The destination x is flit bits [15:14] and the destination y is flit bits [13:12]. The node sits at (1,2) by default. East adds 1 to x, west subtracts 1 from x, north adds 1 to y and south subtracts 1 from y, all modulo 4. For a flit sent on output o other than local, the output queue-select is computed as follows. Route XY at the neighbour in direction o: if x differs, go east or west; otherwise, if y differs, go north or south; otherwise, go local. Call that output n. Let a be the port opposite o. The queue-select is n when n<a, and n-1 otherwise. On the local output the queue-select is 0.
- R6: Each output is granted by a round-robin arbiter. The arbiter takes the first eligible input at or after its pointer, counting upward modulo 5. After a grant, the pointer moves to the winner plus 1.
- R7: A queue is eligible only when two conditions hold: it is non-empty, and the counter for the downstream queue named by its head flit's queue-select is non-zero. That counter decrements on each send and increments on each credit-in pulse. Credit-in bit o*4+k serves queue k behind output o.
- R8: A head flit that loses arbitration stays in its queue unchanged, and it competes again in the next cycle.
- R9: An input queue that is blocked for lack of credit does not delay a flit in another queue of the same input.
- R10: Different outputs may each send one flit in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inFlit | input | 80 | Incoming flit per port, port p in bits [p*16+:16] |
| inValid | input | 5 | Incoming flit valid per port |
| inQsel | input | 10 | Target queue select per port, [p*2+:2] |
| creditOut | output | 20 | Credit return upstream, bit p*4+q for queue q of input p |
| outFlit | output | 80 | Outgoing flit per port |
| outValid | output | 5 | Outgoing flit valid per port |
| outQsel | output | 10 | Look-ahead queue select for the downstream node |
| creditIn | input | 20 | Credit pulses from downstream, bit o*4+k |

## Verification
The bench sweeps every input port, every queue select and all sixteen destinations, one flit at a time. For each flit it checks the output port, the data, the look-ahead queue-select code and the exact arrival cycle. A swapped queue mapping would send flits to the wrong output. An off-by-one direction offset would corrupt the downstream queue-select. An extra pipeline stage would show up as a late arrival. Four inputs are made to contend for a single output, and the order of grants is compared against a round-robin model. An arbiter whose pointer lands on the winner, rather than just past it, would starve the other inputs. If a losing queue dropped its head flit, whole flits would go missing. In further tests the bench withholds credits and checks that exactly four flits leave, and then exactly one more flit per returned credit. A blocked queue alongside a free queue on the same input exposes head-of-line coupling. Two flits sent together show whether outputs are served in parallel.

// File: rtl/vroute_pkg.sv
package vroute_pkg;
  localparam int NPORT   = 5;
  localparam int NVQ     = NPORT - 1;
  localparam int PORT_W  = 3;
  localparam int VQ_W    = 2;
  localparam int COORD_W = 2;

  typedef enum logic [PORT_W-1:0] {
    PORT_LOCAL = 3'd0,
    PORT_NORTH = 3'd1,
    PORT_SOUTH = 3'd2,
    PORT_EAST  = 3'd3,
    PORT_WEST  = 3'd4
  } port_e;

  // control to datapath strobes
  typedef struct packed {
    logic [NPORT-1:0][NVQ-1:0]    pop;
    logic [NPORT-1:0][PORT_W-1:0] pick;
    logic [NPORT-1:0]             fire;
  } strobe_t;

  // queue slot at input inP that serves output outP
  function automatic logic [VQ_W-1:0] vqIndex(input logic [PORT_W-1:0] outP,
                                              input logic [PORT_W-1:0] inP);
    logic [PORT_W-1:0] t;
    t = (outP < inP) ? outP : outP - 3'd1;
    return t[VQ_W-1:0];
  endfunction

  // output served by queue slot q of input inP
  function automatic logic [PORT_W-1:0] vqTarget(input logic [VQ_W-1:0] q,
                                                 input logic [PORT_W-1:0] inP);
    logic [PORT_W-1:0] w;
    w = {1'b0, q};
    return (w < inP) ? w : w + 3'd1;
  endfunction

  function automatic logic [PORT_W-1:0] opposite(input logic [PORT_W-1:0] p);
    case (p)
      PORT_NORTH: return PORT_SOUTH;
      PORT_SOUTH: return PORT_NORTH;
      PORT_EAST:  return PORT_WEST;
      PORT_WEST:  return PORT_EAST;
      default:    return PORT_LOCAL;
    endcase
  endfunction

  function automatic logic [PORT_W-1:0] xyRoute(input logic [COORD_W-1:0] cx,
                                                input logic [COORD_W-1:0] cy,
                                                input logic [COORD_W-1:0] dx,
                                                input logic [COORD_W-1:0] dy);
    if (dx > cx) return PORT_EAST;
    if (dx < cx) return PORT_WEST;
    if (dy > cy) return PORT_NORTH;
    if (dy < cy) return PORT_SOUTH;
    return PORT_LOCAL;
  endfunction

  // queue select the neighbour behind outP needs for this destination
  function automatic logic [VQ_W-1:0] nextQsel(input logic [PORT_W-1:0]  outP,
                                               input logic [COORD_W-1:0] myX,
                                               input logic [COORD_W-1:0] myY,
                                               input logic [COORD_W-1:0] dx,
                                               input logic [COORD_W-1:0] dy);
    logic [COORD_W-1:0] nx, ny;
    nx = myX;
    ny = myY;
    case (outP)
      PORT_NORTH: ny = myY + 2'd1;
      PORT_SOUTH: ny = myY - 2'd1;
      PORT_EAST:  nx = myX + 2'd1;
      PORT_WEST:  nx = myX - 2'd1;
      default: ;
    endcase
    if (outP == PORT_LOCAL) return '0;
    return vqIndex(xyRoute(nx, ny, dx, dy), opposite(outP));
  endfunction
endpackage

// File: rtl/vroute_fifo.sv
module vroute_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         notEmpty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] count;
  logic          full;

  assign dout     = mem[rdPtr];
  assign notEmpty = (count != '0);
  assign full     = (count == CW'(DEPTH));

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= bump(wrPtr);
      if (pop)  rdPtr <= bump(rdPtr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R7: credit flow never lets the upstream sender overrun a queue
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    push |-> !full);

  // R4: control only dequeues a queue that holds a flit
  a_r4_pop_nonempty: assert property (@(posedge clk) disable iff (!rstN)
    pop |-> notEmpty);

  // R8: a head flit that was not taken stays as it was
  a_r8_head_hold: assert property (@(posedge clk) disable iff (!rstN)
    (notEmpty && !pop) |=> $stable(dout));
endmodule

// File: rtl/vroute_datapath.sv
module vroute_datapath
  import vroute_pkg::*;
#(
  parameter int FLIT_W = 16,
  parameter int DEPTH  = 4,
  parameter int MY_X   = 1,
  parameter int MY_Y   = 2
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic [NPORT-1:0][FLIT_W-1:0]       inFlit,
  input  logic [NPORT-1:0]                   inValid,
  input  logic [NPORT-1:0][VQ_W-1:0]         inQsel,
  input  strobe_t                            strb,
  output logic [NPORT-1:0][NVQ-1:0]          vqReady,
  output logic [NPORT-1:0][NVQ-1:0][VQ_W-1:0] headNext,
  output logic [NPORT-1:0][FLIT_W-1:0]       outFlit,
  output logic [NPORT-1:0]                   outValid,
  output logic [NPORT-1:0][VQ_W-1:0]         outQsel,
  output logic [NPORT-1:0][NVQ-1:0]          creditOut
);
  localparam logic [COORD_W-1:0] CX = COORD_W'(MY_X);
  localparam logic [COORD_W-1:0] CY = COORD_W'(MY_Y);

  logic [NPORT-1:0][NVQ-1:0][FLIT_W-1:0] head;
  logic [NPORT-1:0][FLIT_W-1:0]          xbFlit;
  logic [NPORT-1:0][VQ_W-1:0]            xbQsel;

  assign creditOut = strb.pop;

  for (genvar p = 0; p < NPORT; p++) begin : g_in
    for (genvar q = 0; q < NVQ; q++) begin : g_vq
      vroute_fifo #(.W(FLIT_W), .DEPTH(DEPTH)) u_fifo (
        .clk      (clk),
        .rstN     (rstN),
        .push     (inValid[p] && (inQsel[p] == VQ_W'(q))),
        .din      (inFlit[p]),
        .pop      (strb.pop[p][q]),
        .dout     (head[p][q]),
        .notEmpty (vqReady[p][q])
      );
      assign headNext[p][q] = nextQsel(vqTarget(VQ_W'(q), PORT_W'(p)), CX, CY,
                                       head[p][q][FLIT_W-1 -: COORD_W],
                                       head[p][q][FLIT_W-1-COORD_W -: COORD_W]);
    end
  end

  // crossbar: each output picks the head of its winner's queue
  for (genvar o = 0; o < NPORT; o++) begin : g_xb
    always_comb begin
      xbFlit[o] = '0;
      xbQsel[o] = '0;
      for (int p = 0; p < NPORT; p++) begin
        if (p != o && strb.pick[o] == PORT_W'(p)) begin
          xbFlit[o] = head[p][vqIndex(PORT_W'(o), PORT_W'(p))];
          xbQsel[o] = headNext[p][vqIndex(PORT_W'(o), PORT_W'(p))];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= '0;
      outFlit  <= '0;
      outQsel  <= '0;
    end else begin
      outValid <= strb.fire;
      for (int o = 0; o < NPORT; o++) begin
        if (strb.fire[o]) begin
          outFlit[o] <= xbFlit[o];
          outQsel[o] <= xbQsel[o];
        end
      end
    end
  end
endmodule

// File: rtl/vroute_control.sv
module vroute_control
  import vroute_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic [NPORT-1:0][NVQ-1:0]            vqReady,
  input  logic [NPORT-1:0][NVQ-1:0][VQ_W-1:0]  headNext,
  input  logic [NPORT-1:0][NVQ-1:0]            creditIn,
  output strobe_t                              strb
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [NPORT-1:0][NVQ-1:0][CW-1:0] cred;
  logic [NPORT-1:0][PORT_W-1:0]      ptr;
  logic [NPORT-1:0][NPORT-1:0]       elig;
  logic [NPORT-1:0][PORT_W-1:0]      winV;
  logic [NPORT-1:0]                  fireV;
  logic [NPORT-1:0][VQ_W-1:0]        chosenNext;

  always_comb begin
    elig = '0;
    for (int o = 0; o < NPORT; o++) begin
      for (int p = 0; p < NPORT; p++) begin
        if (p != o) begin
          elig[o][p] = vqReady[p][vqIndex(PORT_W'(o), PORT_W'(p))] &&
            (cred[o][headNext[p][vqIndex(PORT_W'(o), PORT_W'(p))]] != '0);
        end
      end
    end
  end

  // round-robin pick per output, scanning upward from the pointer
  always_comb begin
    int idx;
    fireV = '0;
    winV  = '0;
    for (int o = 0; o < NPORT; o++) begin
      for (int i = 0; i < NPORT; i++) begin
        idx = int'(ptr[o]) + i;
        if (idx >= NPORT) idx = idx - NPORT;
        if (!fireV[o] && elig[o][idx]) begin
          fireV[o] = 1'b1;
          winV[o]  = PORT_W'(idx);
        end
      end
    end
  end

  always_comb begin
    strb       = '0;
    chosenNext = '0;
    strb.fire  = fireV;
    strb.pick  = winV;
    for (int o = 0; o < NPORT; o++) begin
      for (int p = 0; p < NPORT; p++) begin
        if (p != o && fireV[o] && winV[o] == PORT_W'(p)) begin
          strb.pop[p][vqIndex(PORT_W'(o), PORT_W'(p))] = 1'b1;
          chosenNext[o] = headNext[p][vqIndex(PORT_W'(o), PORT_W'(p))];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr <= '0;
      for (int o = 0; o < NPORT; o++)
        for (int k = 0; k < NVQ; k++)
          cred[o][k] <= CW'(DEPTH);
    end else begin
      for (int o = 0; o < NPORT; o++) begin
        if (fireV[o])
          ptr[o] <= (winV[o] == PORT_W'(NPORT - 1)) ? '0 : winV[o] + 1'b1;
        for (int k = 0; k < NVQ; k++) begin
          case ({creditIn[o][k], fireV[o] && chosenNext[o] == VQ_W'(k)})
            2'b10:   cred[o][k] <= cred[o][k] + 1'b1;
            2'b01:   cred[o][k] <= cred[o][k] - 1'b1;
            default: cred[o][k] <= cred[o][k];
          endcase
        end
      end
    end
  end

  for (genvar o = 0; o < NPORT; o++) begin : g_chk
    // R6: pointer always names a real port
    a_r6_ptr_range: assert property (@(posedge clk) disable iff (!rstN)
      ptr[o] < PORT_W'(NPORT));
    for (genvar k = 0; k < NVQ; k++) begin : g_k
      // R7: downstream never returns more credits than it has slots
      a_r7_credit_bound: assert property (@(posedge clk) disable iff (!rstN)
        cred[o][k] <= CW'(DEPTH));
      // R7: an exhausted counter stays empty until a credit arrives
      a_r7_credit_hold: assert property (@(posedge clk) disable iff (!rstN)
        (cred[o][k] == '0 && !creditIn[o][k]) |=> cred[o][k] == '0);
    end
  end
endmodule

// File: rtl/vroute_top.sv
module vroute_top
  import vroute_pkg::*;
#(
  parameter int FLIT_W   = 16,
  parameter int VQ_DEPTH = 4,
  parameter int MY_X     = 1,
  parameter int MY_Y     = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [NPORT*FLIT_W-1:0] inFlit,
  input  logic [NPORT-1:0]        inValid,
  input  logic [NPORT*VQ_W-1:0]   inQsel,
  output logic [NPORT*NVQ-1:0]    creditOut,
  output logic [NPORT*FLIT_W-1:0] outFlit,
  output logic [NPORT-1:0]        outValid,
  output logic [NPORT*VQ_W-1:0]   outQsel,
  input  logic [NPORT*NVQ-1:0]    creditIn
);
  strobe_t                                strb;
  logic [NPORT-1:0][NVQ-1:0]              vqReady;
  logic [NPORT-1:0][NVQ-1:0][VQ_W-1:0]    headNext;
  logic [NPORT-1:0][FLIT_W-1:0]           inFlitA, outFlitA;
  logic [NPORT-1:0][VQ_W-1:0]             inQselA, outQselA;
  logic [NPORT-1:0][NVQ-1:0]              creditOutA, creditInA;

  assign inFlitA   = inFlit;
  assign inQselA   = inQsel;
  assign creditInA = creditIn;
  assign outFlit   = outFlitA;
  assign outQsel   = outQselA;
  assign creditOut = creditOutA;

  vroute_datapath #(.FLIT_W(FLIT_W), .DEPTH(VQ_DEPTH), .MY_X(MY_X), .MY_Y(MY_Y)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .inFlit    (inFlitA),
    .inValid   (inValid),
    .inQsel    (inQselA),
    .strb      (strb),
    .vqReady   (vqReady),
    .headNext  (headNext),
    .outFlit   (outFlitA),
    .outValid  (outValid),
    .outQsel   (outQselA),
    .creditOut (creditOutA)
  );

  vroute_control #(.DEPTH(VQ_DEPTH)) u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .vqReady  (vqReady),
    .headNext (headNext),
    .creditIn (creditInA),
    .strb     (strb)
  );
endmodule

// File: tb/vroute_top_test.sv
module vroute_top_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [79:0] inFlit = '0;
  logic [4:0]  inValid = '0;
  logic [9:0]  inQsel = '0;
  logic [19:0] creditOut;
  logic [79:0] outFlit;
  logic [4:0]  outValid;
  logic [9:0]  outQsel;
  logic [19:0] autoCredit = '0;
  logic [19:0] manualCredit = '0;
  logic [19:0] creditIn;
  bit          autoOn = 1'b1;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int logN = 0;
  int logPort [1024];
  int logData [1024];
  int logQsel [1024];
  int logCyc  [1024];

  assign creditIn = autoCredit | manualCredit;

  always #10 clk = ~clk;

  vroute_top uut (
    .clk(clk), .rstN(rstN), .inFlit(inFlit), .inValid(inValid), .inQsel(inQsel),
    .creditOut(creditOut), .outFlit(outFlit), .outValid(outValid),
    .outQsel(outQsel), .creditIn(creditIn)
  );

  // downstream model: record departures, optionally hand credits back
  always @(negedge clk) begin
    cyc = cyc + 1;
    autoCredit = '0;
    for (int o = 0; o < 5; o++) begin
      if (outValid[o]) begin
        if (logN < 1024) begin
          logPort[logN] = o;
          logData[logN] = int'(outFlit[o*16 +: 16]);
          logQsel[logN] = int'(outQsel[o*2 +: 2]);
          logCyc[logN]  = cyc;
        end
        logN = logN + 1;
        if (autoOn) autoCredit[o*4 + int'(outQsel[o*2 +: 2])] = 1'b1;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #2;
  endtask

  task automatic doReset();
    step();
    inValid = '0;
    manualCredit = '0;
    rstN = 1'b0;
    step(); step();
    rstN = 1'b1;
  endtask

  function automatic int refTarget(int p, int q);
    return (q < p) ? q : q + 1;
  endfunction

  function automatic int refRoute(int cx, int cy, int dx, int dy);
    if (dx > cx) return 3;
    if (dx < cx) return 4;
    if (dy > cy) return 1;
    if (dy < cy) return 2;
    return 0;
  endfunction

  function automatic int refQsel(int o, int d);
    int nx, ny, n, a;
    nx = 1; ny = 2;
    if (o == 0) return 0;
    if (o == 1) ny = (ny + 1) % 4;
    if (o == 2) ny = (ny + 3) % 4;
    if (o == 3) nx = (nx + 1) % 4;
    if (o == 4) nx = (nx + 3) % 4;
    n = refRoute(nx, ny, d / 4, d % 4);
    a = (o == 1) ? 2 : (o == 2) ? 1 : (o == 3) ? 4 : 3;
    return (n < a) ? n : n - 1;
  endfunction

  task automatic drive(input int p, input int q, input int data);
    inValid[p] = 1'b1;
    inQsel[p*2 +: 2] = 2'(q);
    inFlit[p*16 +: 16] = 16'(data);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int base, c0, tag, cnt;
    doReset();
    step();
    // R1: quiet outputs after reset
    check(outValid == '0, "R1 outValid after reset", int'(outValid), 0);
    check(creditOut == '0, "R1 creditOut after reset", int'(creditOut), 0);

    // R2 R3 R4 R5: every port, queue and destination, one flit at a time
    tag = 0;
    for (int p = 0; p < 5; p++) begin
      for (int q = 0; q < 4; q++) begin
        for (int d = 0; d < 16; d++) begin
          int data, o;
          data = (d << 12) | (tag & 12'hfff);
          tag++;
          o = refTarget(p, q);
          base = logN;
          step();
          drive(p, q, data);
          c0 = cyc;
          step();
          inValid = '0;
          check(creditOut == 20'(1 << (p*4 + q)), "R4 credit return",
                int'(creditOut), 1 << (p*4 + q));
          step();
          check(logN == base + 1, "R3 one departure", logN - base, 1);
          check(logPort[base] == o, "R2 output port", logPort[base], o);
          check(logData[base] == data, "R3 data intact", logData[base], data);
          check(logCyc[base] == c0 + 2, "R3 latency", logCyc[base] - c0, 2);
          check(logQsel[base] == refQsel(o, d), "R5 lookahead qsel",
                logQsel[base], refQsel(o, d));
        end
      end
    end

    // R6 R8: four inputs contend for east, two flits each
    doReset();
    base = logN;
    step();
    for (int s = 0; s < 2; s++) begin
      for (int p = 0; p < 5; p++)
        if (p != 3) drive(p, (p == 4) ? 3 : 2, 16'hE000 | (p << 4) | s);
      if (s == 0) c0 = cyc;
      step();
    end
    inValid = '0;
    repeat (12) step();
    check(logN == base + 8, "R6 contention count", logN - base, 8);
    for (int i = 0; i < 8; i++) begin
      int src, exp;
      src = (i % 4 == 3) ? 4 : i % 4;
      exp = 16'hE000 | (src << 4) | (i / 4);
      check(logData[base+i] == exp, "R6 round-robin order / R8 retained flit",
            logData[base+i], exp);
      check(logCyc[base+i] == c0 + 2 + i, "R6 back-to-back grants",
            logCyc[base+i] - c0, 2 + i);
    end

    // R7: only four flits go without credit return, then one per credit
    doReset();
    autoOn = 1'b0;
    base = logN;
    for (int i = 0; i < 6; i++) begin
      step();
      drive(4, 3, 16'hE100 | i);
    end
    step();
    inValid = '0;
    repeat (8) step();
    check(logN - base == 4, "R7 stall at zero credit (reset count 4)", logN - base, 4);
    check(logQsel[base] == 3, "R7 target downstream queue", logQsel[base], 3);
    manualCredit[15] = 1'b1;
    step();
    manualCredit = '0;
    repeat (4) step();
    check(logN - base == 5, "R7 one credit one flit", logN - base, 5);
    manualCredit[15] = 1'b1;
    step();
    manualCredit = '0;
    repeat (4) step();
    check(logN - base == 6, "R7 second credit", logN - base, 6);
    check(logData[base+5] == 16'hE105, "R7 order kept", logData[base+5], 16'hE105);

    // R9: east queue of west input is starved, north queue must still flow
    base = logN;
    step(); drive(4, 3, 16'hE200);
    step(); drive(4, 3, 16'hE201);
    step(); drive(4, 1, 16'h7055);
    c0 = cyc;
    step();
    inValid = '0;
    repeat (4) step();
    check(logN - base == 1, "R9 only unblocked flit leaves", logN - base, 1);
    check(logPort[base] == 1, "R9 north port", logPort[base], 1);
    check(logCyc[base] == c0 + 2, "R9 not delayed", logCyc[base] - c0, 2);
    check(logQsel[base] == refQsel(1, 7), "R9 qsel", logQsel[base], refQsel(1, 7));

    // R10 and R1: after reset, two outputs fire together
    doReset();
    autoOn = 1'b1;
    base = logN;
    step();
    drive(0, 0, 16'h7A01);
    drive(4, 3, 16'hEA02);
    c0 = cyc;
    step();
    inValid = '0;
    repeat (5) step();
    cnt = logN - base;
    check(cnt == 2, "R1 queues flushed / R10 two departures", cnt, 2);
    check(logCyc[base] == c0 + 2 && logCyc[base+1] == c0 + 2,
          "R10 same cycle", logCyc[base+1] - logCyc[base], 0);
    check(logPort[base] == 1 && logPort[base+1] == 3, "R10 ports",
          logPort[base] * 10 + logPort[base+1], 13);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule